// File: doc/BRIEF.md
# Serial Block Interleaver and Deinterleaver

This block reorders a serial bit stream so that a short burst of channel errors is spread over several error-correction codewords instead of wiping out one of them. A frame holds `NBLK` blocks (default 8, called A to H) of `BLEN` bits each (default 10). Bits arrive one per `in_valid` cycle in natural order: every bit of block A, then every bit of block B, and so on. The forward variant sends the frame out column by column. Each column starts with the last block. The same core built with the inverse setting undoes this reordering at the receiving end.

Two frame buffers alternate roles. One buffer fills from the input while the other drains to the output, so a continuous input gives a continuous output one frame later. An output frame starts only when every bit of the input frame has been captured. Its first bit is marked with a frame-start flag. The input is framed by counting accepted bits from reset.

Top module: `blk_interleaver`

## Requirements
- R1: A frame is NBLK x BLEN bits (block 0 = A is the first block written), and every accepted input bit produces exactly one output bit, one frame later.
- R2: With DIR = ILV_FWD, output position k of a frame carries natural bit n = (NBLK-1 - k mod NBLK)*BLEN + k div NBLK, i.e. first bit of H, first of G, ... first of A, then second of H, and so on, ending with the last bit of A.
- R3: With DIR = ILV_INV, the block applies the exact inverse reordering, so a forward instance chained into an inverse instance returns the original frames bit for bit.
- R4: out_valid stays low until a complete frame has been accepted; a partial frame produces no output however long the input pauses.
- R5: out_sof is high on the first output bit of each frame and on no other cycle, and only together with out_valid.
- R6: The first bit of an output frame appears on the outputs two clock edges after the edge that accepts the last input bit of that frame, and the frame then leaves on consecutive cycles.
- R7: With in_valid held high across frames, the output has no idle cycle between frames and no frame is lost.
- R8: Cycles with in_valid low are ignored: the value on in_bit then does not reach any output and the position counter does not move.
- R9: A burst of NBLK consecutive errors on the forward output, starting at any position, shows up after the inverse instance as exactly one wrong bit in each block of the affected frame.
- R10: A synchronous active-low reset clears out_valid and out_sof on the next edge and restarts framing at the first bit of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input bit qualifier |
| in_bit | input | 1 | Serial input bit |
| out_valid | output | 1 | Output bit qualifier |
| out_bit | output | 1 | Serial output bit |
| out_sof | output | 1 | High with the first output bit of a frame |

## Verification
A wrong write counter or bank select shows at the ports as frames that start at the wrong moment or hold bits from the neighbouring frame. The bench sees this within one frame, because the start flag no longer falls two edges after the 80th accepted bit. A wrong read address keeps the timing right but puts bits in the wrong positions. The bench catches it on the first frame by comparing each position with the computed permutation. Chaining the forward and inverse instances also finds a mismatch between the two orderings: the round trip no longer returns the original bits, and an injected burst no longer lands once in each block.

// File: rtl/ilv_pkg.sv
`timescale 1ns/1ps
// Shared types for the block interleaver.
// Assumes: nothing beyond the standard language.
package ilv_pkg;
    // Direction of the reordering: forward spreads blocks, inverse restores them.
    typedef enum logic {
        ILV_FWD = 1'b0,
        ILV_INV = 1'b1
    } ilv_dir_e;
endpackage

// File: rtl/ilv_wr_ctrl.sv
`timescale 1ns/1ps
// Write side: counts accepted input bits through a frame and selects which
// of the two frame buffers is being filled.
// Assumes: FRAME >= 2; in_valid qualifies exactly one bit per cycle.
module ilv_wr_ctrl #(
    parameter int FRAME = 80,
    parameter int AW    = $clog2(FRAME)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic [AW-1:0] wr_addr,
    output logic          wr_bank,
    output logic          frame_done
);
    localparam logic [AW-1:0] LAST = AW'(FRAME - 1);

    // The frame completes on the cycle its last bit is accepted.
    assign frame_done = in_valid && (wr_addr == LAST);

    // Advance the position; at the end of a frame swap to the other buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_bank <= 1'b0;
        end else if (in_valid) begin
            if (wr_addr == LAST) begin
                wr_addr <= '0;
                wr_bank <= ~wr_bank;
            end else begin
                wr_addr <= wr_addr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ilv_rd_seq.sv
`timescale 1ns/1ps
// Read side: walks one full frame in the output order after each start pulse
// and produces the buffer address of the bit to send.
// Forward: outer loop over bit position, inner loop over blocks from last to
// first. Inverse: outer loop over blocks, inner loop over bit position, with
// the address pointing at where the forward order placed that bit.
// Assumes: NBLK >= 2 and BLEN >= 2; a start pulse may coincide with the last
// step of the previous frame and then takes priority.
module ilv_rd_seq
    import ilv_pkg::*;
#(
    parameter int       NBLK = 8,
    parameter int       BLEN = 10,
    parameter ilv_dir_e DIR  = ILV_FWD,
    parameter int       AW   = $clog2(NBLK * BLEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_bank,
    output logic          active,
    output logic          rd_bank,
    output logic [AW-1:0] rd_addr,
    output logic          first
);
    localparam int IN_N  = (DIR == ILV_FWD) ? NBLK : BLEN;
    localparam int OUT_N = (DIR == ILV_FWD) ? BLEN : NBLK;
    localparam int IW    = $clog2(IN_N);
    localparam int OW    = $clog2(OUT_N);

    logic [IW-1:0] inner;
    logic [OW-1:0] outer;

    // Step the nested counters through one frame, then go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            rd_bank <= 1'b0;
            inner   <= '0;
            outer   <= '0;
        end else if (start) begin
            active  <= 1'b1;
            rd_bank <= start_bank;
            inner   <= '0;
            outer   <= '0;
        end else if (active) begin
            if (inner == IW'(IN_N - 1)) begin
                inner <= '0;
                if (outer == OW'(OUT_N - 1)) begin
                    outer  <= '0;
                    active <= 1'b0;
                end else begin
                    outer <= outer + 1'b1;
                end
            end else begin
                inner <= inner + 1'b1;
            end
        end
    end

    assign first = active && (inner == '0) && (outer == '0);

    // Address mapping chosen by the direction parameter.
    generate
        if (DIR == ILV_FWD) begin : g_fwd
            // inner = block counted from the last, outer = bit position.
            assign rd_addr = AW'(NBLK - 1 - int'(inner)) * AW'(BLEN) + AW'(outer);
        end else begin : g_inv
            // outer = block, inner = bit position; forward index of that bit.
            assign rd_addr = AW'(inner) * AW'(NBLK) + AW'(NBLK - 1) - AW'(outer);
        end
    endgenerate
endmodule

// File: rtl/ilv_bank.sv
`timescale 1ns/1ps
// Two frame buffers, one written and one read per cycle, with a registered
// read port.
// Assumes: the controllers never read and write the same buffer in one cycle;
// buffer contents need no reset.
module ilv_bank #(
    parameter int FRAME = 80,
    parameter int AW    = $clog2(FRAME)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit
);
    logic [FRAME-1:0] mem_q [2];

    generate
        for (genvar b = 0; b < 2; b++) begin : g_buf
            // Store the incoming bit into this buffer when it is selected.
            always_ff @(posedge clk) begin
                if (wr_en && (wr_bank == 1'(b))) begin
                    mem_q[b][wr_addr] <= wr_bit;
                end
            end
        end
    endgenerate

    // Registered read of the addressed bit from the draining buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bit <= 1'b0;
        end else begin
            rd_bit <= mem_q[rd_bank][rd_addr];
        end
    end
endmodule

// File: rtl/blk_interleaver.sv
`timescale 1ns/1ps
// Serial block interleaver / deinterleaver with two alternating frame buffers.
// DIR = ILV_FWD spreads each column of the NBLK x BLEN frame over the output
// with blocks in reverse order; DIR = ILV_INV restores natural order.
// Assumes: framing starts at the first accepted bit after reset; at most one
// input bit per cycle, so draining a frame never outlasts filling the next.
module blk_interleaver
    import ilv_pkg::*;
#(
    parameter int       NBLK = 8,
    parameter int       BLEN = 10,
    parameter ilv_dir_e DIR  = ILV_FWD
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_bit,
    output logic out_valid,
    output logic out_bit,
    output logic out_sof
);
    localparam int FRAME = NBLK * BLEN;
    localparam int AW    = $clog2(FRAME);

    logic [AW-1:0] wr_addr;
    logic          wr_bank;
    logic          frame_done;
    logic          rd_active;
    logic          rd_bank;
    logic [AW-1:0] rd_addr;
    logic          rd_first;

    ilv_wr_ctrl #(.FRAME(FRAME), .AW(AW)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .wr_addr    (wr_addr),
        .wr_bank    (wr_bank),
        .frame_done (frame_done)
    );

    ilv_rd_seq #(.NBLK(NBLK), .BLEN(BLEN), .DIR(DIR), .AW(AW)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (frame_done),
        .start_bank (wr_bank),
        .active     (rd_active),
        .rd_bank    (rd_bank),
        .rd_addr    (rd_addr),
        .first      (rd_first)
    );

    ilv_bank #(.FRAME(FRAME), .AW(AW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_valid),
        .wr_bank (wr_bank),
        .wr_addr (wr_addr),
        .wr_bit  (in_bit),
        .rd_bank (rd_bank),
        .rd_addr (rd_addr),
        .rd_bit  (out_bit)
    );

    // Align valid and frame-start with the registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
        end else begin
            out_valid <= rd_active;
            out_sof   <= rd_first;
        end
    end
endmodule

// File: rtl/ilv_checker.sv
`timescale 1ns/1ps
// Port-level protocol checker for blk_interleaver, attached by bind.
// Assumes: the same framing rules as the design (count from reset).
module ilv_checker #(
    parameter int NBLK = 8,
    parameter int BLEN = 10
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic out_valid,
    input logic out_sof
);
    localparam int FRAME = NBLK * BLEN;
    localparam int AW    = $clog2(FRAME);

    logic [AW-1:0] icnt;
    logic          seen_frame;
    logic [AW:0]   ocnt;

    // Independent count of accepted input bits and of output bits per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            icnt       <= '0;
            seen_frame <= 1'b0;
            ocnt       <= '0;
        end else begin
            if (in_valid) begin
                if (icnt == AW'(FRAME - 1)) begin
                    icnt       <= '0;
                    seen_frame <= 1'b1;
                end else begin
                    icnt <= icnt + 1'b1;
                end
            end
            if (out_valid) begin
                ocnt <= out_sof ? (AW+1)'(1) : ocnt + 1'b1;
            end
        end
    end

    a_r4_wait_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> seen_frame);

    a_r5_sof_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    a_r5_sof_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (ocnt == '0 || ocnt == (AW+1)'(FRAME)));

    a_r6_start_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && icnt == AW'(FRAME - 1)) |=> ##1 out_sof);

    a_r7_no_gap_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sof && ocnt < (AW+1)'(FRAME - 1)) |=> (out_valid && !out_sof));

    a_r7_sof_continues: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |=> (out_valid && !out_sof));

    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_sof));
endmodule

bind blk_interleaver ilv_checker #(.NBLK(NBLK), .BLEN(BLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_sof   (out_sof)
);

// File: tb/tb_blk_interleaver.sv
`timescale 1ns/1ps
// Directed bench: forward instance (dut) chained into an inverse instance,
// with a burst of channel errors injected between them in one frame.
module tb_blk_interleaver;
    import ilv_pkg::*;

    localparam int NB = 8;
    localparam int BL = 10;
    localparam int FR = NB * BL;
    localparam int NF = 6;
    localparam int NT = NF * FR;
    localparam int B0 = 3 * FR + 13;

    logic clk = 1'b0;
    logic rst_n, in_valid, in_bit;
    logic i_valid, i_bit, i_sof;
    logic d_valid, d_bit, d_sof;
    logic flip;

    logic sent   [NT];
    logic i_cap  [NT];
    logic i_sofc [NT];
    logic d_cap  [NT];
    logic d_sofc [NT];
    int   i_stamp[NT];
    int   i_n = 0, d_n = 0, cyc = 0, chan_cnt = 0;
    int   checks = 0, errors = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    blk_interleaver #(.NBLK(NB), .BLEN(BL), .DIR(ILV_FWD)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
        .out_valid(i_valid), .out_bit(i_bit), .out_sof(i_sof));

    blk_interleaver #(.NBLK(NB), .BLEN(BL), .DIR(ILV_INV)) u_deint (
        .clk(clk), .rst_n(rst_n), .in_valid(i_valid), .in_bit(i_bit ^ flip),
        .out_valid(d_valid), .out_bit(d_bit), .out_sof(d_sof));

    // Channel position counter: at an edge it holds the index of the bit being taken.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) chan_cnt <= 0;
        else if (i_valid) chan_cnt <= chan_cnt + 1;
    end
    assign flip = i_valid && (chan_cnt >= B0) && (chan_cnt < B0 + NB);

    // Capture both output streams away from the active edge.
    always @(negedge clk) begin
        if (i_valid && i_n < NT) begin
            i_cap[i_n] = i_bit; i_sofc[i_n] = i_sof; i_stamp[i_n] = cyc; i_n++;
        end
        if (d_valid && d_n < NT) begin
            d_cap[d_n] = d_bit; d_sofc[d_n] = d_sof; d_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic b);
        @(negedge clk);
        in_valid = v;
        in_bit   = b;
    endtask

    // R10: outputs quiet during and after reset.
    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_bit = 1'b0;
        repeat (3) @(negedge clk);
        chk(i_valid == 1'b0, "R10", "out_valid in reset", int'(i_valid), 0);
        chk(i_sof == 1'b0, "R10", "out_sof in reset", int'(i_sof), 0);
        rst_n = 1'b1;
    endtask

    // R4 and R6: partial frame gives nothing; last bit starts output two edges later.
    task automatic t_partial_then_latency();
        bit seen = 1'b0;
        for (int n = 0; n < FR - 1; n++) drive(1'b1, sent[n]);
        for (int w = 0; w < 12; w++) begin
            drive(1'b0, 1'b1);
            if (i_valid) seen = 1'b1;
        end
        chk(!seen, "R4", "output during partial frame", int'(seen), 0);
        drive(1'b1, sent[FR-1]);
        drive(1'b0, 1'b0);
        chk(i_valid == 1'b0, "R6", "out_valid one edge after last bit", int'(i_valid), 0);
        @(negedge clk);
        chk(i_valid && i_sof, "R6", "valid+sof two edges after last bit",
            int'({i_valid, i_sof}), 3);
    endtask

    // R7: frames 1..4 back to back.
    task automatic t_stream();
        int gaps = 0;
        for (int f = 1; f <= 4; f++)
            for (int n = 0; n < FR; n++) drive(1'b1, sent[f*FR+n]);
        drive(1'b0, 1'b0);
        repeat (FR + 4) @(negedge clk);
        for (int k = FR; k < 5*FR - 1; k++)
            if (i_stamp[k+1] - i_stamp[k] != 1) gaps++;
        chk(gaps == 0, "R7", "idle cycles inside continuous output", gaps, 0);
    endtask

    // R8: frame 5 with idle cycles carrying the wrong bit value.
    task automatic t_gaps();
        for (int n = 0; n < FR; n++) begin
            drive(1'b1, sent[5*FR+n]);
            if (n % 3 == 0) drive(1'b0, ~sent[5*FR+n]);
        end
        drive(1'b0, 1'b0);
        repeat (3*FR) @(negedge clk);
    endtask

    // R1, R2, R5, R8: forward order and frame flags.
    task automatic t_forward_order();
        chk(i_n == NT, "R1", "forward output bit count", i_n, NT);
        for (int f = 0; f < NF; f++) begin
            int bad = 0, sbad = 0;
            for (int k = 0; k < FR; k++) begin
                int n = (NB - 1 - k % NB) * BL + k / NB;
                if (i_cap[f*FR+k] !== sent[f*FR+n]) bad++;
                if (i_sofc[f*FR+k] !== (k == 0)) sbad++;
            end
            chk(bad == 0, (f == 5) ? "R8" : "R2", $sformatf("frame %0d order mismatches", f), bad, 0);
            chk(sbad == 0, "R5", $sformatf("frame %0d sof misplaced", f), sbad, 0);
        end
    endtask

    // R3 round trip and R9 burst spread.
    task automatic t_roundtrip_and_burst();
        int per_blk[NB];
        chk(d_n == NT, "R3", "inverse output bit count", d_n, NT);
        for (int f = 0; f < NF; f++) begin
            int bad = 0;
            if (f == 3) continue;
            for (int n = 0; n < FR; n++)
                if (d_cap[f*FR+n] !== sent[f*FR+n] || d_sofc[f*FR+n] !== (n == 0)) bad++;
            chk(bad == 0, "R3", $sformatf("frame %0d round-trip mismatches", f), bad, 0);
        end
        for (int b = 0; b < NB; b++) per_blk[b] = 0;
        for (int n = 0; n < FR; n++)
            if (d_cap[3*FR+n] !== sent[3*FR+n]) per_blk[n / BL]++;
        for (int b = 0; b < NB; b++)
            chk(per_blk[b] == 1, "R9", $sformatf("errors in block %0d", b), per_blk[b], 1);
    endtask

    initial begin
        for (int n = 0; n < NT; n++) sent[n] = 1'($urandom);
        t_reset();
        t_partial_then_latency();
        t_stream();
        t_gaps();
        t_forward_order();
        t_roundtrip_and_burst();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule